// File: doc/BRIEF.md
# Micro-Page Address Remapping Table

This block sits in front of a DRAM controller and gives every physical address one extra level of indirection. The address is split into a 1 KB micro-page number (the upper bits) and a 10-bit byte offset. The micro-page number is compared against a small fully associative table. Each table entry pairs the original micro-page number with a slot in a reserved 4 MB DRAM region. On a hit, the micro-page number is replaced by the region base and the slot index, and the offset is kept. On a miss, the address goes through unchanged. The original address therefore stays valid for software after the data has moved.

The table is filled in bulk at epoch boundaries, after the copy engine has moved the hot micro-pages into the reserved rows. An update port installs a mapping, drops a mapping or flushes the whole table. While an update runs, the request path holds ready low, so no lookup ever sees a table that is only partly written. An address that already points into the reserved region is flagged as an error and goes through unmodified.

Top module: `mpage_remap`

## Requirements
- R1: Bits [9:0] of every response address equal bits [9:0] of the request that produced it.
- R2: On a hit, the response address is {cfg_base, slot index, offset}, with cfg_base in bits [31:22] and the 12-bit slot in bits [21:10], and rsp_hit is 1.
- R3: On a miss, the response address equals the request address, and rsp_hit and rsp_err are 0.
- R4: A request is accepted when req_valid and req_ready are both 1. rsp_valid is 1 in exactly the cycle after each accepted request and is 0 otherwise.
- R5: A request whose bits [31:22] equal cfg_base gives rsp_err=1 and rsp_hit=0, and its address passes through unmodified.
- R6: req_ready is 0 in every cycle in which upd_busy or upd_valid is 1. A request held during that time is accepted only after both are low.
- R7: Installing a key that is already present overwrites the slot of that entry. A later drop of that key leaves no mapping for it, which shows there is no duplicate.
- R8: upd_op=2'b10 (drop) removes the mapping for upd_key, and later requests to that micro-page miss.
- R9: upd_op=2'b11 (flush) clears every entry.
- R10: After reset, the table is empty, rsp_valid is 0 and req_ready is 1.
- R11: upd_op=2'b01 (install) of a new key goes to the lowest free entry. When the table is full, the install is discarded and the existing mappings stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 10 | Bits [31:22] of the reserved-region base (4 MB aligned) |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Physical request address |
| rsp_valid | output | 1 | Response valid, one cycle after accept |
| rsp_addr | output | 32 | Remapped or passed-through address |
| rsp_hit | output | 1 | Address was remapped |
| rsp_err | output | 1 | Request pointed directly into the reserved region |
| upd_busy | input | 1 | Epoch update in progress; stalls requests |
| upd_valid | input | 1 | Table update command valid |
| upd_op | input | 2 | 01 install, 10 drop, 11 flush, 00 no operation |
| upd_key | input | 22 | Micro-page number (address bits [31:10]) |
| upd_slot | input | 12 | Destination slot in the reserved region |

## Verification
The assertions check the fixed one-cycle response timing, the stall during updates, the kept offset, and the port-level form of misses, region errors and hits on every cycle. Whether a hit occurred at all, which slot it carries, whether an overwrite left a duplicate behind, and whether drop, flush and the full-table discard leave the table in the right state depend on the table history. Only the bench scenarios, which compare against their own model, can show these.

// File: rtl/mpage_remap_pkg.sv
package mpage_remap_pkg;
   typedef enum logic [1:0] {
      UPD_NOP     = 2'b00,
      UPD_INSTALL = 2'b01,
      UPD_DROP    = 2'b10,
      UPD_FLUSH   = 2'b11
   } upd_op_e;
endpackage

// File: rtl/mpage_cam_entry.sv
module mpage_cam_entry #(
   parameter int KEY_W  = 22,
   parameter int SLOT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              clr_en,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [KEY_W-1:0]  lk_key,
   output logic              ent_valid,
   output logic              lk_match,
   output logic              up_match,
   output logic [SLOT_W-1:0] ent_slot
);
   logic [KEY_W-1:0] ent_key;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_valid <= 1'b0;
         ent_key   <= '0;
         ent_slot  <= '0;
      end else if (wr_en) begin
         ent_valid <= 1'b1;
         ent_key   <= wr_key;
         ent_slot  <= wr_slot;
      end else if (clr_en) begin
         ent_valid <= 1'b0;
      end
   end

   assign lk_match = ent_valid && (ent_key == lk_key);
   assign up_match = ent_valid && (ent_key == wr_key);
endmodule

// File: rtl/mpage_remap_table.sv
module mpage_remap_table
   import mpage_remap_pkg::*;
#(
   parameter int KEY_W   = 22,
   parameter int SLOT_W  = 12,
   parameter int ENTRIES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid,
   input  upd_op_e           upd_op,
   input  logic [KEY_W-1:0]  upd_key,
   input  logic [SLOT_W-1:0] upd_slot,
   input  logic [KEY_W-1:0]  lk_key,
   output logic              lk_hit,
   output logic [SLOT_W-1:0] lk_slot
);
   logic [ENTRIES-1:0] valid_v, lk_v, up_v, wr_v, clr_v, free_v, free_first;
   logic [SLOT_W-1:0]  slot_a [ENTRIES];
   logic               do_install;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
         mpage_cam_entry #(.KEY_W(KEY_W), .SLOT_W(SLOT_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_v[i]),
            .clr_en   (clr_v[i]),
            .wr_key   (upd_key),
            .wr_slot  (upd_slot),
            .lk_key   (lk_key),
            .ent_valid(valid_v[i]),
            .lk_match (lk_v[i]),
            .up_match (up_v[i]),
            .ent_slot (slot_a[i])
         );
      end
   endgenerate

   // lowest free entry, isolated by two's complement
   assign free_v     = ~valid_v;
   assign free_first = free_v & (~free_v + 1'b1);
   assign do_install = upd_valid && (upd_op == UPD_INSTALL);

   always_comb begin
      wr_v  = '0;
      clr_v = '0;
      if (do_install) begin
         wr_v = (|up_v) ? up_v : free_first;
      end
      if (upd_valid && upd_op == UPD_DROP)  clr_v = up_v;
      if (upd_valid && upd_op == UPD_FLUSH) clr_v = '1;
   end

   always_comb begin
      lk_slot = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_v[i]) lk_slot = lk_slot | slot_a[i];
      end
   end

   assign lk_hit = |lk_v;
endmodule

// File: rtl/mpage_remap.sv
module mpage_remap
   import mpage_remap_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OFS_W   = 10,
   parameter int SLOT_W  = 12,
   parameter int ENTRIES = 16,
   localparam int KEY_W  = ADDR_W - OFS_W,
   localparam int BASE_W = ADDR_W - OFS_W - SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BASE_W-1:0] cfg_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_hit,
   output logic              rsp_err,
   input  logic              upd_busy,
   input  logic              upd_valid,
   input  logic [1:0]        upd_op,
   input  logic [KEY_W-1:0]  upd_key,
   input  logic [SLOT_W-1:0] upd_slot
);
   generate
      if (ENTRIES < 2 || BASE_W < 1 || OFS_W < 1) begin : g_bad_cfg
         $error("mpage_remap: illegal parameter combination");
      end
   endgenerate

   logic              accept, in_region, tbl_hit, use_map;
   logic [SLOT_W-1:0] tbl_slot;

   assign req_ready = !upd_busy && !upd_valid;
   assign accept    = req_valid && req_ready;
   assign in_region = (req_addr[ADDR_W-1 -: BASE_W] == cfg_base);
   assign use_map   = tbl_hit && !in_region;

   mpage_remap_table #(.KEY_W(KEY_W), .SLOT_W(SLOT_W), .ENTRIES(ENTRIES)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_valid(upd_valid),
      .upd_op   (upd_op_e'(upd_op)),
      .upd_key  (upd_key),
      .upd_slot (upd_slot),
      .lk_key   (req_addr[ADDR_W-1:OFS_W]),
      .lk_hit   (tbl_hit),
      .lk_slot  (tbl_slot)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_hit   <= 1'b0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_err  <= in_region;
            rsp_hit  <= use_map;
            rsp_addr <= use_map ? {cfg_base, tbl_slot, req_addr[OFS_W-1:0]} : req_addr;
         end
      end
   end
endmodule

// File: rtl/mpage_remap_chk.sv
module mpage_remap_chk #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 10,
   parameter int BASE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BASE_W-1:0] cfg_base,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic              rsp_hit,
   input logic              rsp_err,
   input logic              upd_busy,
   input logic              upd_valid
);
   p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_busy || upd_valid) |-> !req_ready);

   p_resp_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !rsp_valid);

   p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rsp_addr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0])));

   p_miss_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!rsp_hit -> rsp_addr == $past(req_addr)));

   p_region_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_addr[ADDR_W-1 -: BASE_W] == cfg_base)
      |=> (rsp_err && !rsp_hit && rsp_addr == $past(req_addr)));

   p_hit_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> (rsp_addr[ADDR_W-1 -: BASE_W] == cfg_base));
endmodule

bind mpage_remap mpage_remap_chk #(
   .ADDR_W(ADDR_W), .OFS_W(OFS_W), .BASE_W(BASE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
   .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
   .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
   .upd_busy(upd_busy), .upd_valid(upd_valid)
);

// File: tb/mpage_remap_tb_top.sv
module mpage_remap_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ENT = 4;
   localparam logic [9:0] BASE = 10'h3F0;

   logic        clk = 0, rst_n = 0;
   logic        req_valid = 0, req_ready;
   logic [31:0] req_addr = '0;
   logic        rsp_valid, rsp_hit, rsp_err;
   logic [31:0] rsp_addr;
   logic        upd_busy = 0, upd_valid = 0;
   logic [1:0]  upd_op = '0;
   logic [21:0] upd_key = '0;
   logic [11:0] upd_slot = '0;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   logic [33:0] exp_q [$];
   string       tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mpage_remap #(.ENTRIES(ENT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_base(BASE),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
      .upd_busy(upd_busy), .upd_valid(upd_valid), .upd_op(upd_op),
      .upd_key(upd_key), .upd_slot(upd_slot)
   );

   function automatic logic [31:0] mapped(input logic [11:0] s, input logic [31:0] a);
      return {BASE, s, a[9:0]};
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compare every response with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && rsp_valid && !done) begin
         if (exp_q.size() == 0) begin
            check("R4 unexpected response", 64'(rsp_addr), 64'hDEAD);
         end else begin
            logic [33:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 64'({rsp_addr, rsp_hit, rsp_err}), 64'(e));
         end
      end
   end

   task automatic push(input string tag, input logic [31:0] ea, input logic h, input logic er);
      exp_q.push_back({ea, h, er});
      tag_q.push_back(tag);
   endtask

   task automatic send(input string tag, input logic [31:0] a, input logic [31:0] ea,
                       input logic h, input logic er);
      @(negedge clk);
      req_valid = 1; req_addr = a;
      push(tag, ea, h, er);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic upd(input logic [1:0] op, input logic [21:0] k, input logic [11:0] s);
      @(negedge clk);
      upd_valid = 1; upd_op = op; upd_key = k; upd_slot = s;
      #1 check("R6 ready during update", 64'(req_ready), 64'd0);
      @(negedge clk);
      upd_valid = 0; upd_op = 2'b00;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] a0, a1, a2, a3, a4;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10 rsp_valid in reset", 64'(rsp_valid), 64'd0);
      rst_n = 1;
      @(negedge clk);
      check("R10 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      check("R10 ready after reset", 64'(req_ready), 64'd1);

      a0 = 32'h1234_5678;
      send("R10 empty table misses", a0, a0, 0, 0);
      send("R3 miss passes through", 32'h0000_03FF, 32'h0000_03FF, 0, 0);

      upd(2'b01, a0[31:10], 12'd5);
      send("R2 hit remap", a0, mapped(12'd5, a0), 1, 0);
      send("R1 offset zero", {a0[31:10], 10'h000}, mapped(12'd5, 32'h0), 1, 0);
      send("R1 offset max", {a0[31:10], 10'h3FF}, mapped(12'd5, 32'h3FF), 1, 0);

      // back-to-back requests, one response per cycle (R4)
      @(negedge clk);
      req_valid = 1; req_addr = a0; push("R4 burst first", mapped(12'd5, a0), 1, 0);
      @(negedge clk);
      req_addr = 32'h0BAD_0C00; push("R4 burst second", 32'h0BAD_0C00, 0, 0);
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);
      check("R4 queue drained", 64'(exp_q.size()), 64'd0);

      send("R5 region access", 32'hFC12_3456, 32'hFC12_3456, 0, 1);
      upd(2'b01, 22'h3F0_123 >> 0, 12'd7);
      send("R5 region wins over table", 32'hFC04_8C00, 32'hFC04_8C00, 0, 1);

      // stall during epoch update (R6)
      @(negedge clk);
      upd_busy = 1; req_valid = 1; req_addr = a0;
      repeat (3) begin
         #1 check("R6 ready while busy", 64'(req_ready), 64'd0);
         @(negedge clk);
         check("R6 no response while busy", 64'(rsp_valid), 64'd0);
      end
      upd_busy = 0;
      push("R6 held request accepted", mapped(12'd5, a0), 1, 0);
      @(negedge clk);
      req_valid = 0;

      // overwrite existing key (R7)
      upd(2'b01, a0[31:10], 12'd9);
      send("R7 overwrite slot", a0, mapped(12'd9, a0), 1, 0);
      upd(2'b10, a0[31:10], 12'd0);
      send("R7 no duplicate after drop", a0, a0, 0, 0);
      send("R8 drop misses", a0 + 32'h4, a0 + 32'h4, 0, 0);

      // fill the table, next install is discarded (R11)
      upd(2'b11, '0, '0);
      a1 = 32'h0001_0400; a2 = 32'h0002_0800; a3 = 32'h0003_0C00; a4 = 32'h0004_1000;
      upd(2'b01, a0[31:10], 12'd1);
      upd(2'b01, a1[31:10], 12'd2);
      upd(2'b01, a2[31:10], 12'd3);
      upd(2'b01, a3[31:10], 12'd4);
      upd(2'b01, a4[31:10], 12'd6);
      send("R11 full table discards", a4, a4, 0, 0);
      send("R11 entry0 kept", a0, mapped(12'd1, a0), 1, 0);
      send("R11 entry3 kept", a3, mapped(12'd4, a3), 1, 0);
      upd(2'b10, a1[31:10], 12'd0);
      upd(2'b01, a4[31:10], 12'd6);
      send("R11 reuse freed entry", a4, mapped(12'd6, a4), 1, 0);
      send("R8 dropped key misses", a1, a1, 0, 0);

      upd(2'b11, '0, '0);
      send("R9 flush a0", a0, a0, 0, 0);
      send("R9 flush a4", a4, a4, 0, 0);

      repeat (3) @(negedge clk);
      check("R4 all responses seen", 64'(exp_q.size()), 64'd0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule